// File: doc/BRIEF.md
# Packed SIMD Compare and Min/Max Unit

This unit works on two 128-bit vector operands split into equal lanes of 8, 16 or 32 bits. For every lane it either builds a mask (all ones where the A element is strictly greater than the B element), or returns the larger or the smaller of the two elements. A single input chooses whether the elements are read as signed or unsigned. The same datapath serves 16, 8 or 4 lanes.

A compare issued with the record bit set also produces a 4-bit condition summary. The summary shows whether every lane of the mask came out true or every lane came out false. A write-enable pulse marks the cycle in which the surrounding logic should store it. Results appear one clock after the operands, tagged by a valid strobe. The last summary written stays on its output until the next recorded compare.

Top module: `simd_cmp_unit`

## Requirements
- R1: `lane_sz` picks the lane width: 0 gives 16 lanes of 8 bits, 1 gives 8 lanes of 16 bits, and 2 or 3 give 4 lanes of 32 bits. Lane 0 occupies the most significant bits, and lane k occupies the next lower slice after lane k-1.
- R2: With `op_sel` = 0 (compare), each result lane is all ones when the A element is strictly greater than the B element, and all zeros otherwise, including when the two are equal.
- R3: With `signed_en` = 1, elements are two's-complement numbers. With `signed_en` = 0 they are unsigned. This holds for every lane size and every operation.
- R4: With `op_sel` = 1 (maximum), each lane returns the A element when A > B, and the B element otherwise.
- R5: With `op_sel` = 2 (minimum), each lane returns the A element when A < B, and the B element otherwise.
- R6: With `op_sel` = 3 (reserved), the result is all zeros and no condition write occurs.
- R7: On a recorded compare, `cond_out` takes {all lanes true, 0, all lanes false, 0} in bit order 3..0. The update lands in the same cycle as `valid_out`.
- R8: `cond_we` pulses only for a valid compare with `rec_en` = 1. Every other operation leaves `cond_out` unchanged.
- R9: `valid_out` repeats `valid_in` one clock later. `result_out` loads only when `valid_in` is high and otherwise holds its value.
- R10: While `rst` is high, `valid_out`, `cond_we`, `result_out` and `cond_out` are all cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| a_in | input | 128 | Operand A |
| b_in | input | 128 | Operand B |
| lane_sz | input | 2 | Lane width select |
| signed_en | input | 1 | Signed interpretation of elements |
| op_sel | input | 2 | 0 compare, 1 maximum, 2 minimum, 3 reserved |
| rec_en | input | 1 | Record the condition summary on a compare |
| valid_out | output | 1 | Result is valid |
| result_out | output | 128 | Mask or selected elements |
| cond_we | output | 1 | Condition summary write strobe |
| cond_out | output | 4 | Last recorded condition summary |

## Verification
The hardest case to reach is a wide lane whose upper bytes are equal, so that a lower byte decides the outcome. This matters most when the sign of the top byte would have reversed an unsigned decision. Independent random operands almost never share their upper bytes. For this reason, half of the random stimulus derives B from A by flipping bits inside a single byte, which creates many lanes that are equal or nearly equal. Directed cases reach the other corner: operands with 0x80 against 0x7F in every byte, which separate the signed reading from the unsigned one. The all-true and all-false summaries are also forced through identical and strictly dominating operands.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LS_BYTE = 2'd0,
        LS_HALF = 2'd1,
        LS_WORD = 2'd2,
        LS_WIDE = 2'd3
    } lane_sz_e;

    typedef enum logic [1:0] {
        OP_CMPGT = 2'd0,
        OP_MAX   = 2'd1,
        OP_MIN   = 2'd2,
        OP_RSVD  = 2'd3
    } vop_e;

    // relation of one byte of A to the same byte of B
    typedef struct packed {
        logic gt_u;
        logic gt_s;
        logic eq;
    } byte_rel_t;

    // selector into the per-size merge results: 0 -> 1 byte, 1 -> 2, 2 -> 4
    function automatic int unsigned size_index(input lane_sz_e s);
        case (s)
            LS_BYTE: return 0;
            LS_HALF: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic logic [3:0] cond_pack(input logic all_true, input logic all_false);
        return {all_true, 1'b0, all_false, 1'b0};
    endfunction

endpackage

// File: rtl/simd_byte_cmp.sv
module simd_byte_cmp
    import simd_cmp_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output byte_rel_t    rel
);
    always_comb begin
        rel.gt_u = a > b;
        rel.gt_s = $signed(a) > $signed(b);
        rel.eq   = a == b;
    end
endmodule

// File: rtl/simd_lane_merge.sv
module simd_lane_merge
    import simd_cmp_pkg::*;
#(
    parameter int NB = 16
) (
    input  byte_rel_t [NB-1:0] rel,
    input  lane_sz_e           sz,
    input  logic               sgn,
    output logic [NB-1:0]      a_gt,
    output logic [NB-1:0]      a_lt
);
    localparam int NSZ = 3;

    logic [NSZ-1:0][NB-1:0] gt_by_sz;
    logic [NSZ-1:0][NB-1:0] lt_by_sz;

    for (genvar gi = 0; gi < NSZ; gi++) begin : g_size
        localparam int G = 1 << gi;
        for (genvar ln = 0; ln < NB / G; ln++) begin : g_lane
            localparam int BASE = ln * G;
            logic lgt;
            logic leq;
            // byte BASE is the most significant byte of the lane
            always_comb begin
                lgt = sgn ? rel[BASE].gt_s : rel[BASE].gt_u;
                leq = rel[BASE].eq;
                for (int j = 1; j < G; j++) begin
                    lgt = lgt | (leq & rel[BASE + j].gt_u);
                    leq = leq & rel[BASE + j].eq;
                end
            end
            assign gt_by_sz[gi][BASE +: G] = {G{lgt}};
            assign lt_by_sz[gi][BASE +: G] = {G{~lgt & ~leq}};
        end
    end

    always_comb begin
        a_gt = gt_by_sz[size_index(sz)];
        a_lt = lt_by_sz[size_index(sz)];
    end
endmodule

// File: rtl/simd_result_sel.sv
module simd_result_sel
    import simd_cmp_pkg::*;
#(
    parameter int NB = 16
) (
    input  logic [NB*BYTE_W-1:0] a,
    input  logic [NB*BYTE_W-1:0] b,
    input  logic [NB-1:0]        a_gt,
    input  logic [NB-1:0]        a_lt,
    input  vop_e                 op,
    output logic [NB*BYTE_W-1:0] res,
    output logic                 all_true,
    output logic                 all_false
);
    localparam int VW = NB * BYTE_W;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam int HI = VW - 1 - i * BYTE_W;
        logic [BYTE_W-1:0] ab;
        logic [BYTE_W-1:0] bb;
        assign ab = a[HI -: BYTE_W];
        assign bb = b[HI -: BYTE_W];
        always_comb begin
            case (op)
                OP_CMPGT: res[HI -: BYTE_W] = {BYTE_W{a_gt[i]}};
                OP_MAX:   res[HI -: BYTE_W] = a_gt[i] ? ab : bb;
                OP_MIN:   res[HI -: BYTE_W] = a_lt[i] ? ab : bb;
                default:  res[HI -: BYTE_W] = '0;
            endcase
        end
    end

    assign all_true  = &res;
    assign all_false = ~|res;
endmodule

// File: rtl/simd_cmp_unit.sv
module simd_cmp_unit
    import simd_cmp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic [VEC_W-1:0] a_in,
    input  logic [VEC_W-1:0] b_in,
    input  logic [1:0]       lane_sz,
    input  logic             signed_en,
    input  logic [1:0]       op_sel,
    input  logic             rec_en,
    output logic             valid_out,
    output logic [VEC_W-1:0] result_out,
    output logic             cond_we,
    output logic [3:0]       cond_out
);
    localparam int NB = VEC_W / BYTE_W;

    byte_rel_t [NB-1:0] rel;
    logic [NB-1:0]      a_gt;
    logic [NB-1:0]      a_lt;
    logic [VEC_W-1:0]   res_c;
    logic               all_true_c;
    logic               all_false_c;
    vop_e               op_c;
    lane_sz_e           sz_c;
    logic               rec_c;

    assign op_c  = vop_e'(op_sel);
    assign sz_c  = lane_sz_e'(lane_sz);
    assign rec_c = valid_in & rec_en & (op_c == OP_CMPGT);

    for (genvar i = 0; i < NB; i++) begin : g_cmp
        localparam int HI = VEC_W - 1 - i * BYTE_W;
        simd_byte_cmp #(.W(BYTE_W)) i_byte (
            .a   (a_in[HI -: BYTE_W]),
            .b   (b_in[HI -: BYTE_W]),
            .rel (rel[i])
        );
    end

    simd_lane_merge #(.NB(NB)) i_merge (
        .rel  (rel),
        .sz   (sz_c),
        .sgn  (signed_en),
        .a_gt (a_gt),
        .a_lt (a_lt)
    );

    simd_result_sel #(.NB(NB)) i_sel (
        .a         (a_in),
        .b         (b_in),
        .a_gt      (a_gt),
        .a_lt      (a_lt),
        .op        (op_c),
        .res       (res_c),
        .all_true  (all_true_c),
        .all_false (all_false_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out  <= 1'b0;
            cond_we    <= 1'b0;
            result_out <= '0;
            cond_out   <= '0;
        end else begin
            valid_out <= valid_in;
            cond_we   <= rec_c;
            if (valid_in) result_out <= res_c;
            if (rec_c)    cond_out   <= cond_pack(all_true_c, all_false_c);
        end
    end
endmodule

// File: rtl/simd_cmp_chk.sv
module simd_cmp_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_in,
    input logic [1:0]       op_sel,
    input logic             valid_out,
    input logic [VEC_W-1:0] result_out,
    input logic             cond_we,
    input logic [3:0]       cond_out
);
    localparam int NB = VEC_W / 8;

    logic bytes_uniform;
    always_comb begin
        bytes_uniform = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (result_out[i*8 +: 8] != 8'h00 && result_out[i*8 +: 8] != 8'hFF)
                bytes_uniform = 1'b0;
        end
    end

    // R2: a compare result is made of whole all-ones or all-zeros bytes
    p_mask_lanes_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op_sel == 2'd0) |=> bytes_uniform);

    // R7: the all-true flag agrees with the registered result
    p_cond_true_r7: assert property (@(posedge clk) disable iff (rst)
        (cond_we && cond_out[3]) |-> (&result_out));

    // R7: the all-false flag agrees with the registered result
    p_cond_false_r7: assert property (@(posedge clk) disable iff (rst)
        (cond_we && cond_out[1]) |-> (result_out == '0));

    // R8: a condition write always comes with a valid result
    p_we_valid_r8: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> valid_out);

    // R8: without a write the summary does not move
    p_cond_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cond_we |-> $stable(cond_out));

    // R9: valid follows one clock behind
    p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R9: an idle cycle keeps the result and drops valid
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> (!valid_out && $stable(result_out)));
endmodule

bind simd_cmp_unit simd_cmp_chk #(.VEC_W(VEC_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_in   (valid_in),
    .op_sel     (op_sel),
    .valid_out  (valid_out),
    .result_out (result_out),
    .cond_we    (cond_we),
    .cond_out   (cond_out)
);

// File: tb/test_simd_cmp_unit.sv
module test_simd_cmp_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_in = 1'b0;
    logic [127:0] a_in = '0;
    logic [127:0] b_in = '0;
    logic [1:0]   lane_sz = '0;
    logic         signed_en = 1'b0;
    logic [1:0]   op_sel = '0;
    logic         rec_en = 1'b0;
    logic         valid_out;
    logic [127:0] result_out;
    logic         cond_we;
    logic [3:0]   cond_out;

    int checks = 0;
    int failures = 0;

    logic [127:0] exp_res = '0;
    logic [3:0]   exp_cond = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_cmp_unit i_simd_cmp_unit (
        .clk(clk), .rst(rst), .valid_in(valid_in), .a_in(a_in), .b_in(b_in),
        .lane_sz(lane_sz), .signed_en(signed_en), .op_sel(op_sel), .rec_en(rec_en),
        .valid_out(valid_out), .result_out(result_out), .cond_we(cond_we), .cond_out(cond_out)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural lane model: element widths 8/16/32, lane 0 at the top (R1)
    function automatic logic [127:0] ref_calc(input logic [127:0] a, input logic [127:0] b,
                                              input int sz, input bit sg, input int op);
        int w;
        int n;
        int sh;
        longint ea;
        longint eb;
        logic [127:0] m;
        logic [127:0] ua;
        logic [127:0] ub;
        logic [127:0] pick;
        logic [127:0] r;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        n = 128 / w;
        m = (128'd1 << w) - 128'd1;
        r = '0;
        for (int l = 0; l < n; l++) begin
            sh = 128 - (l + 1) * w;
            ua = (a >> sh) & m;
            ub = (b >> sh) & m;
            ea = longint'(ua[63:0]);
            eb = longint'(ub[63:0]);
            if (sg && ua[w-1]) ea = ea - (longint'(1) << w);
            if (sg && ub[w-1]) eb = eb - (longint'(1) << w);
            case (op)
                0: pick = (ea > eb) ? m : '0;
                1: pick = (ea > eb) ? ua : ub;
                2: pick = (ea < eb) ? ua : ub;
                default: pick = '0;
            endcase
            r = r | (pick << sh);
        end
        return r;
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0: return "R2";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic step(input logic [127:0] a, input logic [127:0] b, input int sz,
                        input bit sg, input int op, input bit rec, input bit vin);
        logic [127:0] r;
        @(negedge clk);
        a_in = a; b_in = b; lane_sz = 2'(sz); signed_en = sg;
        op_sel = 2'(op); rec_en = rec; valid_in = vin;
        r = ref_calc(a, b, sz, sg, op);
        if (vin) exp_res = r;
        if (vin && op == 0 && rec)
            exp_cond = {r == {128{1'b1}}, 1'b0, r == '0, 1'b0};
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R9 valid_out", 128'(valid_out), 128'(vin));
        chk(vin ? op_tag(op) : "R9 hold", result_out, exp_res);
        chk("R8 cond_we", 128'(cond_we), 128'(vin && op == 0 && rec));
        chk("R7 cond_out", 128'(cond_out), 128'(exp_cond));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] ra;
        logic [127:0] rb;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R10: reset state
        chk("R10 valid_out", 128'(valid_out), 128'd0);
        chk("R10 result_out", result_out, '0);
        chk("R10 cond_we", 128'(cond_we), 128'd0);
        chk("R10 cond_out", 128'(cond_out), 128'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1: only lane 0 greater gives a mask in the top byte
        step({8'hFF, 120'd0}, '0, 0, 0, 0, 1, 1);
        chk("R1 lane0 top byte", result_out, {8'hFF, 120'd0});
        // R1: halfword lane 1 greater
        step({16'd0, 16'd5, 96'd0}, {16'd0, 16'd4, 96'd0}, 1, 0, 0, 0, 1);
        chk("R1 halfword lane1", result_out, {16'h0, 16'hFFFF, 96'd0});

        // R3: 0x80 vs 0x7F differs between signed and unsigned
        step({16{8'h80}}, {16{8'h7F}}, 0, 0, 0, 1, 1);
        chk("R3 unsigned gt", result_out, {128{1'b1}});
        chk("R7 all true", 128'(cond_out), 128'(4'b1000));
        step({16{8'h80}}, {16{8'h7F}}, 0, 1, 0, 1, 1);
        chk("R3 signed not gt", result_out, '0);
        chk("R7 all false", 128'(cond_out), 128'(4'b0010));
        step({16{8'h80}}, {16{8'h7F}}, 2, 1, 1, 0, 1);
        chk("R3 R4 signed word max", result_out, {16{8'h7F}});
        step({16{8'h80}}, {16{8'h7F}}, 1, 0, 2, 0, 1);
        chk("R3 R5 unsigned half min", result_out, {16{8'h7F}});

        // R2: equal operands give a false mask; R7 all false
        step({4{32'h1234_5678}}, {4{32'h1234_5678}}, 2, 0, 0, 1, 1);
        chk("R2 equal lanes", result_out, '0);
        // R7: mixed result gives zero summary
        step({32'd9, 96'd0}, '0, 2, 0, 0, 1, 1);
        chk("R7 mixed", 128'(cond_out), 128'd0);
        // R8: compare without record, max/min with record leave summary
        step({16{8'h01}}, '0, 0, 0, 0, 0, 1);
        chk("R8 unrecorded", 128'(cond_out), 128'd0);
        step({16{8'h01}}, '0, 0, 0, 1, 1, 1);
        chk("R8 max record", 128'(cond_out), 128'd0);
        // R6: reserved op
        step({16{8'h33}}, {16{8'h11}}, 0, 0, 3, 1, 1);
        chk("R6 reserved zero", result_out, '0);
        // R9: idle cycle holds
        step({16{8'hAA}}, {16{8'h55}}, 0, 0, 1, 0, 1);
        step('0, {16{8'hFF}}, 0, 0, 1, 0, 0);
        chk("R9 held", result_out, {16{8'hAA}});

        // random mix, half of it with B a near-copy of A
        for (int it = 0; it < 600; it++) begin
            ra = {$urandom, $urandom, $urandom, $urandom};
            if (it % 2 == 0)
                rb = ra ^ (128'($urandom & 32'hFF) << (8 * ($urandom % 16)));
            else
                rb = {$urandom, $urandom, $urandom, $urandom};
            step(ra, rb, int'($urandom % 4), bit'($urandom % 2), int'($urandom % 4),
                 bit'($urandom % 2), bit'(($urandom % 5) != 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule